// File: doc/BRIEF.md
# Escape-coded extraction stream decoder

This block sits behind a CPU extraction queue that delivers one 32-bit word per valid cycle, with no sideband framing. Frame boundaries are carried in-band by reserved control words in the range 0x80000000 to 0x80000007. An escape word keeps payload transparent: it forces the next word to be taken literally, even if it matches a control code.

Each frame starts with a 9-word internal header. The decoder takes a 7-bit source port and a 30-bit timestamp from that header and reports them. It then sends the payload out as a word-wide stream. The last word carries a count of its valid bytes. Each frame ends with a one-cycle completion pulse, a good or discard flag, and the frame length in bytes without the 4-byte FCS.

The payload stream runs one word behind the input. A data word is only known to be the last one when the word after it arrives. An optional byte-swap mode reverses the bytes of every incoming word before it is decoded. A source port at or above the configured port count makes the decoder drop the rest of that frame without emitting any payload.

Top module: `xtr_stream_decoder`

## Requirements
- R1: After reset, out_valid_o, done_o and hdr_valid_o are all low.
- R2: The first 9 accepted words of a frame are header words, and no control code is interpreted among them. In the normalised words, byte 0 is bits 31:24. tstamp_o equals {w0[13:0], w1[31:16]}, which clears the top two bits of header byte 2. src_port_o equals w7[20:14]. Both are presented with a one-cycle hdr_valid_o pulse, one cycle after the 9th header word is accepted.
- R3: Payload words leave in arrival order. Every word that is not the last has out_last_o=0 and out_bytes_o=4. Each word is emitted in the cycle after the following data word or end code is accepted.
- R4: End word 0x8000000x (x=0..3) ends the frame. It is due one cycle after acceptance and produces all of the following together:
  - the held word with out_last_o=1 and out_bytes_o=4-x;
  - done_o=1 and good_o=1, provided at least one payload word was seen;
  - length_o=4*N-x-4, where N is the number of payload words. The value saturates at 0.
- R5: Word 0x80000007 in the payload is skipped. It adds nothing to the stream or the length.
- R6: After escape word 0x80000006, the next word is taken as payload even if it is a control code.
- R7: After prune word 0x80000004, the next word is taken as payload and then the frame ends. The final word (last, 4 bytes) and done_o with good_o=0 are due two cycles after that payload word is accepted.
- R8: Abort word 0x80000005 ends the frame with no further data. The held word is emitted as last with 4 bytes, and done_o comes with good_o=0, one cycle after the abort word.
- R9: With byte_swap_i=1, each input word is byte-reversed before it is decoded, used as a header word or emitted. The emitted payload is the reversed word.
- R10: A source port greater than or equal to NUM_PORTS (default 65) suppresses every payload output of that frame. Escape and prune are still honoured while the rest of the frame is dropped. The frame ends with done_o, good_o=0 and length_o=0.
- R11: An end word that arrives with no payload gives done_o with good_o=0, length_o=0 and no output word.
- R12: done_o is a single-cycle pulse, exactly one per frame. A frame may start in the cycle right after a prune-terminated frame, and its header is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_swap_i | input | 1 | Byte-reverse each input word before decoding |
| in_valid_i | input | 1 | Input word present this cycle |
| in_word_i | input | 32 | Extraction stream word |
| out_valid_o | output | 1 | Payload word valid |
| out_data_o | output | 32 | Payload word (normalised byte order) |
| out_last_o | output | 1 | Last payload word of the frame |
| out_bytes_o | output | 3 | Valid bytes in this word (1 to 4) |
| hdr_valid_o | output | 1 | Header fields valid pulse |
| src_port_o | output | 7 | Source port from the header |
| tstamp_o | output | 30 | Timestamp from the header |
| done_o | output | 1 | Frame completion pulse |
| good_o | output | 1 | Frame good (1) or discard (0), valid with done_o |
| length_o | output | LEN_W | Frame length in bytes without FCS, valid with done_o |

## Verification
Each word the bench drives is stamped with the number of the clock edge that accepts it. The monitor stamps every output event with the edge that produced it. From these stamps the bench requires the following:
- header fields appear on the same edge as the 9th header word;
- done_o appears on the same edge as an end or abort word;
- for a pruned frame, done_o appears one edge after the trailing payload word.

Payload words are checked by sequence, and every mid-frame word must carry 4 bytes. Outputs are sampled on the falling edge, and stimulus is also changed there, so no comparison depends on process order at the rising edge.

// File: rtl/xtr_stream_decoder.sv
module xtr_stream_decoder #(
  parameter int NUM_PORTS = 65,
  parameter int HDR_WORDS = 9,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_swap_i,
  input  logic             in_valid_i,
  input  logic [31:0]      in_word_i,
  output logic             out_valid_o,
  output logic [31:0]      out_data_o,
  output logic             out_last_o,
  output logic [2:0]       out_bytes_o,
  output logic             hdr_valid_o,
  output logic [6:0]       src_port_o,
  output logic [29:0]      tstamp_o,
  output logic             done_o,
  output logic             good_o,
  output logic [LEN_W-1:0] length_o
);

  localparam int HC_W = $clog2(HDR_WORDS);
  localparam logic [HC_W-1:0] TS_HI_WORD = HC_W'(0);
  localparam logic [HC_W-1:0] TS_LO_WORD = HC_W'(1);
  localparam logic [HC_W-1:0] PORT_WORD  = HC_W'(7);
  localparam logic [HC_W-1:0] LAST_HDR   = HC_W'(HDR_WORDS - 1);
  localparam logic [28:0]     CTL_TAG    = 29'h1000_0000;

  typedef enum logic [1:0] {S_HDR, S_DATA, S_ESC, S_PRN} st_t;

  st_t              st;
  logic [HC_W-1:0]  hcnt;
  logic             drop, held_v, close_pend;
  logic [31:0]      held;
  logic [LEN_W-1:0] wcnt;
  logic [13:0]      ts_hi;
  logic [29:0]      ts_r;
  logic [6:0]       src_r;

  wire [31:0] nw = byte_swap_i ?
                   {in_word_i[7:0], in_word_i[15:8], in_word_i[23:16], in_word_i[31:24]} :
                   in_word_i;
  wire        is_ctl  = nw[31:3] == CTL_TAG;
  wire [2:0]  code    = nw[2:0];
  wire        in_data = in_valid_i && st == S_DATA;
  wire        lit     = in_valid_i && (st == S_ESC || st == S_PRN || (st == S_DATA && !is_ctl));
  wire        eof     = in_data && is_ctl && !code[2];
  wire        abt     = in_data && is_ctl && code == 3'd5;
  wire        fin     = eof || abt || close_pend;
  wire [1:0]  unused  = eof ? code[1:0] : 2'd0;
  wire        emit    = held_v && !drop;
  wire [6:0]  port_f  = nw[20:14];

  wire [LEN_W+1:0] raw_bytes = {wcnt, 2'b00};
  wire [LEN_W+1:0] cut       = (LEN_W+2)'(unused) + (LEN_W+2)'(4);
  wire [LEN_W+1:0] net       = raw_bytes - cut;
  wire [LEN_W-1:0] len_sat   = (raw_bytes >= cut) ? net[LEN_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_HDR;
      hcnt        <= '0;
      drop        <= 1'b0;
      held_v      <= 1'b0;
      close_pend  <= 1'b0;
      held        <= '0;
      wcnt        <= '0;
      ts_hi       <= '0;
      ts_r        <= '0;
      src_r       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
      out_bytes_o <= '0;
      hdr_valid_o <= 1'b0;
      src_port_o  <= '0;
      tstamp_o    <= '0;
      done_o      <= 1'b0;
      good_o      <= 1'b0;
      length_o    <= '0;
    end else begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      done_o      <= 1'b0;
      hdr_valid_o <= 1'b0;

      if (in_valid_i && st == S_HDR) begin
        if (hcnt == TS_HI_WORD) ts_hi <= nw[13:0];
        if (hcnt == TS_LO_WORD) ts_r <= {ts_hi, nw[31:16]};
        if (hcnt == PORT_WORD) begin
          src_r <= port_f;
          drop  <= int'(port_f) >= NUM_PORTS;
        end
        if (hcnt == LAST_HDR) begin
          hcnt        <= '0;
          st          <= S_DATA;
          hdr_valid_o <= 1'b1;
          src_port_o  <= src_r;
          tstamp_o    <= ts_r;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end

      if (lit) begin
        if (emit) begin
          out_valid_o <= 1'b1;
          out_data_o  <= held;
          out_bytes_o <= 3'd4;
        end
        held       <= nw;
        held_v     <= 1'b1;
        wcnt       <= wcnt + 1'b1;
        st         <= (st == S_PRN) ? S_HDR : S_DATA;
        close_pend <= st == S_PRN;
      end else if (in_data && is_ctl) begin
        if (code == 3'd4) st <= S_PRN;
        if (code == 3'd6) st <= S_ESC;
      end

      if (fin) begin
        out_valid_o <= emit;
        out_last_o  <= emit;
        out_data_o  <= held;
        out_bytes_o <= 3'd4 - {1'b0, unused};
        done_o      <= 1'b1;
        good_o      <= eof && emit;
        length_o    <= drop ? '0 : len_sat;
        held_v      <= 1'b0;
        wcnt        <= '0;
        drop        <= 1'b0;
        close_pend  <= 1'b0;
        st          <= S_HDR;
      end
    end
  end

  AST_MID_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_last_o |-> out_bytes_o == 3'd4); // R3

  AST_LAST_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_last_o |-> out_bytes_o != 3'd0 && out_bytes_o <= 3'd4); // R4

  AST_GOOD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && good_o |-> out_valid_o && out_last_o); // R4

  AST_LAST_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_last_o |-> done_o); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R12

  AST_BAD_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid_o && int'(src_port_o) >= NUM_PORTS |=> !out_valid_o); // R10

endmodule

// File: tb/xtr_stream_decoder_tb_top.sv
module xtr_stream_decoder_tb_top;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_swap_i = 1'b0;
  logic in_valid_i = 1'b0;
  logic [31:0] in_word_i = '0;
  logic out_valid_o, out_last_o, hdr_valid_o, done_o, good_o;
  logic [31:0] out_data_o;
  logic [2:0] out_bytes_o;
  logic [6:0] src_port_o;
  logic [29:0] tstamp_o;
  logic [LEN_W-1:0] length_o;

  xtr_stream_decoder #(.NUM_PORTS(65), .HDR_WORDS(9), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .byte_swap_i(byte_swap_i), .in_valid_i(in_valid_i),
    .in_word_i(in_word_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_last_o(out_last_o), .out_bytes_o(out_bytes_o), .hdr_valid_o(hdr_valid_o),
    .src_port_o(src_port_o), .tstamp_o(tstamp_o), .done_o(done_o), .good_o(good_o),
    .length_o(length_o));

  always #10 clk = ~clk;

  localparam logic [31:0] EOF0 = 32'h8000_0000, PRUNE = 32'h8000_0004, ABORT = 32'h8000_0005,
                          ESC = 32'h8000_0006, NRDY = 32'h8000_0007;

  int n_chk = 0, n_err = 0, cyc = 0, acc = 0, hdr_acc = 0;
  bit cur_swap = 0;
  logic [31:0] od[256]; logic ol[256]; logic [2:0] ob[256];
  logic dg[64]; logic [LEN_W-1:0] dl[64]; int dc[64];
  logic [6:0] hs[64]; logic [29:0] ht[64]; int hc[64];
  int no = 0, nd = 0, nh = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (out_valid_o) begin od[no] = out_data_o; ol[no] = out_last_o; ob[no] = out_bytes_o; no++; end
    if (done_o) begin dg[nd] = good_o; dl[nd] = length_o; dc[nd] = cyc; nd++; end
    if (hdr_valid_o) begin hs[nh] = src_port_o; ht[nh] = tstamp_o; hc[nh] = cyc; nh++; end
  end

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid_i = 1'b1;
    byte_swap_i = cur_swap;
    in_word_i = cur_swap ? bsw(w) : w;
    acc = cyc + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid_i = 1'b0;
    end
  endtask

  task automatic send_hdr(input logic [6:0] src, input logic [29:0] ts);
    for (int i = 0; i < 9; i++) begin
      logic [31:0] w;
      w = 32'h1111_0000 + i;
      if (i == 0) w = {16'hA5C3, 2'b11, ts[29:16]};
      if (i == 1) w = {ts[15:0], 16'h1234};
      if (i == 2) w = ABORT;
      if (i == 7) w = (32'hDEAD_BEEF & ~(32'h7F << 14)) | ({25'd0, src} << 14);
      send(w);
    end
    hdr_acc = acc;
  endtask

  task automatic chk_word(input int idx, input logic [31:0] d, input logic l, input logic [2:0] b,
                          input string tag);
    chk(od[idx] == d, {tag, " data"}, od[idx], d);
    chk(ol[idx] == l, {tag, " last"}, 32'(ol[idx]), 32'(l));
    chk(ob[idx] == b, {tag, " bytes"}, 32'(ob[idx]), 32'(b));
  endtask

  task automatic chk_hdr(input int idx, input logic [6:0] src, input logic [29:0] ts, input string tag);
    chk(hs[idx] == src, {tag, " src_port"}, 32'(hs[idx]), 32'(src));
    chk(ht[idx] == ts, {tag, " tstamp"}, 32'(ht[idx]), 32'(ts));
    chk(hc[idx] == hdr_acc, {tag, " hdr cycle"}, hc[idx], hdr_acc);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid_o && !done_o && !hdr_valid_o, "R1 reset strobes", {out_valid_o, done_o, hdr_valid_o}, 0);
  endtask

  task automatic t_basic;
    int o0 = no, d0 = nd, h0 = nh, e;
    send_hdr(7'd5, 30'h2ABC_DEF1);
    send(32'hA0A0_0001); send(32'hA0A0_0002); send(32'hA0A0_0003);
    send(EOF0 | 2); e = acc;
    idle(4);
    chk_hdr(h0, 7'd5, 30'h2ABC_DEF1, "R2 basic");
    chk(no - o0 == 3, "R3 basic count", no - o0, 3);
    chk_word(o0, 32'hA0A0_0001, 0, 4, "R3 word0");
    chk_word(o0 + 1, 32'hA0A0_0002, 0, 4, "R3 word1");
    chk_word(o0 + 2, 32'hA0A0_0003, 1, 2, "R4 last");
    chk(nd - d0 == 1, "R12 one done", nd - d0, 1);
    chk(dg[d0] == 1, "R4 good", 32'(dg[d0]), 1);
    chk(dl[d0] == 6, "R4 length", 32'(dl[d0]), 6);
    chk(dc[d0] == e, "R4 done cycle", dc[d0], e);
  endtask

  task automatic t_esc_nrdy;
    int o0 = no, d0 = nd;
    send_hdr(7'd9, 30'h0000_1111);
    send(32'h0B0B_0001); send(NRDY); send(ESC); send(EOF0 | 3);
    send(NRDY); send(32'h0B0B_0002); send(EOF0);
    idle(4);
    chk(no - o0 == 3, "R5 count", no - o0, 3);
    chk_word(o0 + 1, EOF0 | 3, 0, 4, "R6 escaped literal");
    chk_word(o0 + 2, 32'h0B0B_0002, 1, 4, "R6 last");
    chk(dg[d0] == 1, "R6 good", 32'(dg[d0]), 1);
    chk(dl[d0] == 8, "R5 length", 32'(dl[d0]), 8);
  endtask

  task automatic t_prune_then_next;
    int o0 = no, d0 = nd, h0 = nh, l;
    send_hdr(7'd3, 30'h1555_AAAA);
    send(32'hC0C0_0001); send(32'hC0C0_0002); send(PRUNE); send(ABORT); l = acc;
    send_hdr(7'd64, 30'h3FFF_0001);
    send(32'hD0D0_0001); send(EOF0 | 1);
    idle(4);
    chk(no - o0 == 4, "R7 count", no - o0, 4);
    chk_word(o0 + 2, ABORT, 1, 4, "R7 literal after prune");
    chk(dg[d0] == 0, "R7 discard", 32'(dg[d0]), 0);
    chk(dc[d0] == l + 1, "R7 done cycle", dc[d0], l + 1);
    chk_hdr(h0 + 1, 7'd64, 30'h3FFF_0001, "R12 next header");
    chk(nd - d0 == 2, "R12 two dones", nd - d0, 2);
    chk(dg[d0 + 1] == 1, "R12 next good", 32'(dg[d0 + 1]), 1);
    chk_word(o0 + 3, 32'hD0D0_0001, 1, 3, "R12 next last");
  endtask

  task automatic t_abort;
    int o0 = no, d0 = nd, e;
    send_hdr(7'd1, 30'h0);
    send(32'hE0E0_0001); send(32'hE0E0_0002); send(ABORT); e = acc;
    idle(4);
    chk(no - o0 == 2, "R8 count", no - o0, 2);
    chk_word(o0 + 1, 32'hE0E0_0002, 1, 4, "R8 last");
    chk(dg[d0] == 0, "R8 discard", 32'(dg[d0]), 0);
    chk(dc[d0] == e, "R8 done cycle", dc[d0], e);
  endtask

  task automatic t_swap;
    int o0 = no, d0 = nd, h0 = nh;
    cur_swap = 1;
    send_hdr(7'd33, 30'h0123_4567);
    send(32'h1122_3344); send(ESC); send(ABORT); send(32'h5566_7788); send(EOF0 | 1);
    idle(4);
    cur_swap = 0;
    chk_hdr(h0, 7'd33, 30'h0123_4567, "R9 swap header");
    chk(no - o0 == 3, "R9 count", no - o0, 3);
    chk_word(o0, 32'h1122_3344, 0, 4, "R9 word0");
    chk_word(o0 + 1, ABORT, 0, 4, "R9 escaped");
    chk_word(o0 + 2, 32'h5566_7788, 1, 3, "R9 last");
    chk(dl[d0] == 7, "R9 length", 32'(dl[d0]), 7);
  endtask

  task automatic t_bad_port(input logic [6:0] src);
    int o0 = no, d0 = nd;
    send_hdr(src, 30'h5);
    send(32'hF0F0_0001); send(ESC); send(EOF0); send(32'hF0F0_0002); send(EOF0);
    idle(4);
    chk(no - o0 == 0, "R10 no output", no - o0, 0);
    chk(nd - d0 == 1, "R10 one done", nd - d0, 1);
    chk(dg[d0] == 0, "R10 discard", 32'(dg[d0]), 0);
    chk(dl[d0] == 0, "R10 length", 32'(dl[d0]), 0);
  endtask

  task automatic t_empty_and_sat;
    int o0 = no, d0 = nd;
    send_hdr(7'd2, 30'h7);
    send(NRDY); send(EOF0);
    idle(3);
    chk(no - o0 == 0, "R11 no output", no - o0, 0);
    chk(dg[d0] == 0 && dl[d0] == 0, "R11 discard len0", {dg[d0], dl[d0]}, 0);
    send_hdr(7'd2, 30'h7);
    send(32'h9999_0001); send(EOF0 | 3);
    idle(3);
    chk_word(o0, 32'h9999_0001, 1, 1, "R4 single word");
    chk(dg[d0 + 1] == 1 && dl[d0 + 1] == 0, "R4 saturated length", {dg[d0 + 1], dl[d0 + 1]}, 32'h1_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_esc_nrdy();
    t_prune_then_next();
    t_abort();
    t_swap();
    t_bad_port(7'd65);
    t_bad_port(7'd127);
    t_empty_and_sat();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule